// File: doc/BRIEF.md
# Router Power-Gating Controller

This block decides, for one mesh router, when the router datapath loses and regains its supply. It watches a flag that says the datapath holds no flits, the wake request lines from the four neighbouring routers, and a per-cycle strobe that marks each virtual-channel request made by the local network interface. From these it drives the sleep control of the power switch and a gated status line towards each neighbour.

Power-down is a two-step sequence. The controller first raises the gated status to all neighbours for one notify cycle. Only then, and only if the datapath is still empty, does it assert sleep. Power-up starts on any neighbour's wake request, or when the local interface's request count in a fixed 64-cycle window exceeds a programmable threshold. Sleep then drops at once, but the gated status stays high for a programmable wake delay. During that delay, neighbours hold their traffic back.

The controller also keeps two saturating counters for evaluation. One counts wakeups. The other counts gated periods too short to pay back the energy cost of switching.

Top module: `router_pg_ctrl`

## Requirements
- R1: After reset, sleep is 0, every gated status bit is 0 and both statistics counters read 0.
- R2: While powered and idle (datapath empty, no wake request), the controller raises all gated status bits for exactly one cycle before sleep rises.
- R3: Sleep rises only if the datapath flag was still empty in the notify cycle. A flit arriving in that cycle returns the router to powered with the status cleared and sleep never raised.
- R4: While sleep is high, any one bit of the wake request bus makes sleep fall on the next cycle, with all status bits still high.
- R5: Local requests are counted over consecutive 64-cycle windows. A gated router wakes when a window's count is strictly greater than the threshold input. A count equal to the threshold leaves it asleep.
- R6: After sleep falls, the status bits stay high for exactly N cycles and then clear. N is the 4-bit wake-delay input when it is 10 or more, and 10 otherwise.
- R7: The wakeup counter (8 bits) rises by one on every exit from the gated state and holds at 255.
- R8: The short-idle counter (8 bits) rises by one when sleep was high for fewer than 10 cycles before waking, and holds at 255. A gated period of 10 or more cycles leaves it unchanged.
- R9: Sleep is never high while any status bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dpEmpty | input | 1 | Datapath holds no flits |
| wakeReq | input | 4 | Wake request from each neighbour |
| vcReq | input | 1 | One local virtual-channel request this cycle |
| rateThresh | input | 7 | Request-count threshold per window |
| wakeCycles | input | 4 | Wake delay in cycles (minimum 10 applied) |
| sleep | output | 1 | Power switch off control |
| pgOut | output | 4 | Gated status towards each neighbour |
| wakeCount | output | 8 | Saturating wakeup count |
| shortIdleCount | output | 8 | Saturating count of gated periods below break-even |

## Verification
The hardest situation to reach is a wake caused by the request rate, because it depends on a free-running window whose phase the ports do not show. The stimulus sidesteps the phase by pulsing the request strobe every 16 cycles, which puts exactly four requests in any 64-cycle span. A threshold of four must then hold the router asleep for several windows, and lowering it to three must wake it within two windows. The saturation corners are reached by repeating one-cycle gated periods well over 255 times.

// File: rtl/pg_pkg.sv
package pg_pkg;

  typedef enum logic [1:0] {
    PG_ON     = 2'd0,
    PG_NOTIFY = 2'd1,
    PG_OFF    = 2'd2,
    PG_WAKING = 2'd3
  } pgState_t;

  // strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic enterOff;
    logic leaveOff;
    logic inOff;
    logic inWaking;
  } pgStrobe_t;

endpackage

// File: rtl/pg_ctrl_fsm.sv
module pg_ctrl_fsm
  import pg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      dpEmpty,
  input  logic      anyWake,
  input  logic      rateHit,
  input  logic      wakeDone,
  output pgStrobe_t stb,
  output logic      sleepOn,
  output logic      pgActive
);

  pgState_t state, stateNext;
  logic     wakeCause;

  assign wakeCause = anyWake | rateHit;

  always_comb begin
    stateNext = state;
    unique case (state)
      PG_ON:     if (dpEmpty && !anyWake) stateNext = PG_NOTIFY;
      PG_NOTIFY: stateNext = (dpEmpty && !anyWake) ? PG_OFF : PG_ON;
      PG_OFF:    if (wakeCause) stateNext = PG_WAKING;
      PG_WAKING: if (wakeDone) stateNext = PG_ON;
      default:   stateNext = PG_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PG_ON;
    else       state <= stateNext;
  end

  always_comb begin
    stb.enterOff = (state == PG_NOTIFY) && (stateNext == PG_OFF);
    stb.leaveOff = (state == PG_OFF) && wakeCause;
    stb.inOff    = (state == PG_OFF);
    stb.inWaking = (state == PG_WAKING);
  end

  assign sleepOn  = (state == PG_OFF);
  assign pgActive = (state != PG_ON);

endmodule

// File: rtl/pg_datapath.sv
module pg_datapath
  import pg_pkg::*;
#(
  parameter int WAKE_W   = 4,
  parameter int WAKE_MIN = 10,
  parameter int BET      = 10,
  parameter int WIN      = 64,
  parameter int CNT_W    = 8,
  localparam int WIN_W   = $clog2(WIN),
  localparam int REQ_W   = WIN_W + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  pgStrobe_t         stb,
  input  logic              vcReq,
  input  logic [REQ_W-1:0]  rateThresh,
  input  logic [WAKE_W-1:0] wakeCycles,
  output logic              wakeDone,
  output logic              rateHit,
  output logic [CNT_W-1:0]  wakeCount,
  output logic [CNT_W-1:0]  shortIdleCount
);

  localparam int IDLE_W = $clog2(BET + 1);
  localparam logic [WAKE_W-1:0] WAKE_FLOOR = WAKE_W'(WAKE_MIN);
  localparam logic [IDLE_W-1:0] BET_V      = IDLE_W'(BET);
  localparam logic [WIN_W-1:0]  WIN_LAST   = WIN_W'(WIN - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX    = {CNT_W{1'b1}};

  // wake delay counter
  logic [WAKE_W-1:0] wakeEff, wakeCnt;
  assign wakeEff  = (wakeCycles < WAKE_FLOOR) ? WAKE_FLOOR : wakeCycles;
  assign wakeDone = stb.inWaking && (wakeCnt == WAKE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN)                              wakeCnt <= '0;
    else if (stb.leaveOff)                  wakeCnt <= wakeEff;
    else if (stb.inWaking && wakeCnt != '0) wakeCnt <= wakeCnt - WAKE_W'(1);
  end

  // gated period length, saturating at the break-even value
  logic [IDLE_W-1:0] idleLen;
  logic              shortHit;
  assign shortHit = idleLen < BET_V;

  always_ff @(posedge clk) begin
    if (!rstN)                 idleLen <= '0;
    else if (stb.enterOff)     idleLen <= IDLE_W'(1);
    else if (stb.inOff && !stb.leaveOff && idleLen < BET_V)
                               idleLen <= idleLen + IDLE_W'(1);
  end

  // request-rate window
  logic [WIN_W-1:0] winCnt;
  logic [REQ_W-1:0] reqCnt, reqSum;
  logic             winEnd;
  assign winEnd = (winCnt == WIN_LAST);
  assign reqSum = reqCnt + REQ_W'(vcReq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt  <= '0;
      reqCnt  <= '0;
      rateHit <= 1'b0;
    end else begin
      winCnt  <= winEnd ? '0 : winCnt + WIN_W'(1);
      reqCnt  <= winEnd ? '0 : reqSum;
      rateHit <= winEnd && (reqSum > rateThresh);
    end
  end

  // saturating statistics
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeCount      <= '0;
      shortIdleCount <= '0;
    end else if (stb.leaveOff) begin
      if (wakeCount != CNT_MAX) wakeCount <= wakeCount + CNT_W'(1);
      if (shortHit && shortIdleCount != CNT_MAX)
        shortIdleCount <= shortIdleCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/router_pg_ctrl.sv
module router_pg_ctrl
  import pg_pkg::*;
#(
  parameter int NBR      = 4,
  parameter int WAKE_W   = 4,
  parameter int WAKE_MIN = 10,
  parameter int BET      = 10,
  parameter int WIN      = 64,
  parameter int CNT_W    = 8,
  localparam int REQ_W   = $clog2(WIN) + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dpEmpty,
  input  logic [NBR-1:0]    wakeReq,
  input  logic              vcReq,
  input  logic [REQ_W-1:0]  rateThresh,
  input  logic [WAKE_W-1:0] wakeCycles,
  output logic              sleep,
  output logic [NBR-1:0]    pgOut,
  output logic [CNT_W-1:0]  wakeCount,
  output logic [CNT_W-1:0]  shortIdleCount
);

  pgStrobe_t stb;
  logic      wakeDone, rateHit, pgActive, anyWake;

  assign anyWake = |wakeReq;

  pg_ctrl_fsm i_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .dpEmpty  (dpEmpty),
    .anyWake  (anyWake),
    .rateHit  (rateHit),
    .wakeDone (wakeDone),
    .stb      (stb),
    .sleepOn  (sleep),
    .pgActive (pgActive)
  );

  pg_datapath #(
    .WAKE_W   (WAKE_W),
    .WAKE_MIN (WAKE_MIN),
    .BET      (BET),
    .WIN      (WIN),
    .CNT_W    (CNT_W)
  ) i_dp (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .vcReq          (vcReq),
    .rateThresh     (rateThresh),
    .wakeCycles     (wakeCycles),
    .wakeDone       (wakeDone),
    .rateHit        (rateHit),
    .wakeCount      (wakeCount),
    .shortIdleCount (shortIdleCount)
  );

  for (genvar n = 0; n < NBR; n++) begin : g_pgFan
    assign pgOut[n] = pgActive;
  end

endmodule

// File: rtl/router_pg_checker.sv
module router_pg_checker #(
  parameter int NBR   = 4,
  parameter int CNT_W = 8
)(
  input logic             clk,
  input logic             rstN,
  input logic             dpEmpty,
  input logic [NBR-1:0]   wakeReq,
  input logic             sleep,
  input logic [NBR-1:0]   pgOut,
  input logic [CNT_W-1:0] wakeCount
);

  AST_NOTIFY_BEFORE_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleep) |-> &$past(pgOut));                                  // R2

  AST_SLEEP_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleep) |-> $past(dpEmpty));                                 // R3

  AST_WAKE_ON_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    (sleep && |wakeReq) |=> (!sleep && &pgOut));                      // R4

  AST_STATUS_HELD_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleep) |=> &pgOut);                                         // R6

  AST_WAKE_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleep) |-> ((wakeCount == $past(wakeCount) + CNT_W'(1)) ||
                      (wakeCount == '1 && $past(wakeCount) == '1)));  // R7

  AST_WAKE_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(sleep) |-> $stable(wakeCount));                            // R7

  AST_SLEEP_IMPLIES_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> &pgOut);                                                // R9

endmodule

bind router_pg_ctrl router_pg_checker #(.NBR(NBR), .CNT_W(CNT_W)) i_pgChk (
  .clk       (clk),
  .rstN      (rstN),
  .dpEmpty   (dpEmpty),
  .wakeReq   (wakeReq),
  .sleep     (sleep),
  .pgOut     (pgOut),
  .wakeCount (wakeCount)
);

// File: tb/test_router_pg_ctrl.sv
module test_router_pg_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dpEmpty = 1'b0;
  logic [3:0] wakeReq = '0;
  logic       vcReq = 1'b0;
  logic [6:0] rateThresh = 7'd100;
  logic [3:0] wakeCycles = 4'd12;
  logic       sleep;
  logic [3:0] pgOut;
  logic [7:0] wakeCount, shortIdleCount;

  int checks = 0;
  int fails  = 0;
  int expWake = 0;
  int expShort = 0;

  always #4 clk = ~clk;

  router_pg_ctrl i_router_pg_ctrl (
    .clk(clk), .rstN(rstN), .dpEmpty(dpEmpty), .wakeReq(wakeReq),
    .vcReq(vcReq), .rateThresh(rateThresh), .wakeCycles(wakeCycles),
    .sleep(sleep), .pgOut(pgOut), .wakeCount(wakeCount),
    .shortIdleCount(shortIdleCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkStats(input string req);
    check(wakeCount == 8'(expWake), {req, " wakeCount"}, wakeCount, expWake);
    check(shortIdleCount == 8'(expShort), {req, " shortIdleCount"}, shortIdleCount, expShort);
  endtask

  // from powered state: idle, notify, then gated; returns at first negedge with sleep high
  task automatic enterOff(input bit doCheck);
    @(negedge clk) dpEmpty = 1'b1;
    @(negedge clk);
    if (doCheck) begin
      check(pgOut == 4'hF, "R2 notify status", pgOut, 15);
      check(sleep == 1'b0, "R2 sleep low in notify", sleep, 0);
    end
    @(negedge clk);
    if (doCheck) check(sleep == 1'b1, "R2 sleep after notify", sleep, 1);
    dpEmpty = 1'b0;
  endtask

  // stay gated offLen cycles total, wake via neighbour idx, measure status hold
  task automatic wakeByNbr(input int idx, input int offLen, input int expN, input bit doCheck);
    int held;
    for (int k = 1; k < offLen; k++) @(negedge clk);
    wakeReq[idx] = 1'b1;
    @(negedge clk) wakeReq = '0;
    expWake  = (expWake < 255) ? expWake + 1 : 255;
    if (offLen < 10) expShort = (expShort < 255) ? expShort + 1 : 255;
    if (doCheck) begin
      check(sleep == 1'b0, "R4 sleep drops on request", sleep, 0);
      check(pgOut == 4'hF, "R4 status held", pgOut, 15);
    end
    held = 1;
    while (pgOut != 4'h0 && held < 40) begin
      @(negedge clk);
      if (pgOut != 4'h0) held++;
    end
    if (doCheck) check(held == expN, "R6 wake delay", held, expN);
  endtask

  task automatic testReset();
    check(sleep == 1'b0, "R1 sleep", sleep, 0);
    check(pgOut == 4'h0, "R1 status", pgOut, 0);
    checkStats("R1");
  endtask

  task automatic testDrainAbort();
    @(negedge clk) dpEmpty = 1'b1;
    @(negedge clk);
    check(pgOut == 4'hF, "R3 notify status", pgOut, 15);
    dpEmpty = 1'b0;
    @(negedge clk);
    check(pgOut == 4'h0, "R3 status cleared on abort", pgOut, 0);
    check(sleep == 1'b0, "R3 no sleep on abort", sleep, 0);
    repeat (5) @(negedge clk);
    check(sleep == 1'b0 && pgOut == 4'h0, "R3 stays powered while busy", sleep, 0);
  endtask

  task automatic testNbrWakes();
    wakeCycles = 4'd12;
    enterOff(1'b1);
    wakeByNbr(0, 9, 12, 1'b1);
    checkStats("R8 nine-cycle gate");
    wakeCycles = 4'd15;
    enterOff(1'b1);
    wakeByNbr(3, 10, 15, 1'b1);
    checkStats("R8 ten-cycle gate");
    wakeCycles = 4'd3;
    enterOff(1'b1);
    wakeByNbr(1, 20, 10, 1'b1);
    checkStats("R7 clamped wake");
  endtask

  task automatic testRate();
    int woke = 0;
    int early = 0;
    wakeCycles = 4'd12;
    rateThresh = 7'd4;
    enterOff(1'b1);
    for (int i = 0; i < 320; i++) begin
      vcReq = (i % 16 == 0);
      @(negedge clk);
      if (!sleep) early++;
    end
    check(early == 0, "R5 count equal to threshold keeps gated", early, 0);
    rateThresh = 7'd3;
    for (int i = 320; i < 520 && !woke; i++) begin
      vcReq = (i % 16 == 0);
      @(negedge clk);
      if (!sleep) woke = 1;
    end
    vcReq = 1'b0;
    check(woke == 1, "R5 count above threshold wakes", woke, 1);
    check(pgOut == 4'hF, "R5 status held after rate wake", pgOut, 15);
    expWake++;
    while (pgOut != 4'h0) @(negedge clk);
    checkStats("R5 stats");
    rateThresh = 7'd100;
  endtask

  task automatic testSaturation();
    wakeCycles = 4'd10;
    for (int i = 0; i < 260; i++) begin
      enterOff(1'b0);
      wakeByNbr(i % 4, 1, 10, 1'b0);
    end
    check(wakeCount == 8'd255, "R7 wake counter saturates", wakeCount, 255);
    check(shortIdleCount == 8'd255, "R8 short counter saturates", shortIdleCount, 255);
    check(sleep == 1'b0 && pgOut == 4'h0, "R9 powered after last wake", pgOut, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDrainAbort();
    testNbrWakes();
    testRate();
    testSaturation();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule